// File: doc/BRIEF.md
# Prefixed Opcode Length Decoder

This block sits on a stream of instruction bytes for an 8-bit processor whose opcode space is widened by prefix bytes (CB, DD, ED, FD). It marks instruction boundaries in the stream without executing anything. Each accepted byte comes back one cycle later with a role tag: opcode fetch, displacement or offset, or immediate data. The first byte of every instruction is flagged. The last byte carries an end strobe, the total length in bytes and the prefix class.

Bytes enter through a valid/ready pair. Once reset has been released, ready stays high, so one byte is taken on every cycle in which valid is high. Cycles with valid low leave the decoding state untouched. A front-end can use the tags to split a fetched stream into instructions, to find the displacement byte of indexed forms and to collect immediates. Multi-byte immediates arrive with the low byte first.

Top module: `opcode_len_decoder`

## Requirements
- R1: While rst_n is low, out_valid and in_ready are 0. in_ready rises within three cycles after release. The first byte accepted after reset is an instruction start (out_first=1).
- R2: An unprefixed opcode with no operand bytes ends at once. It has out_last=1, out_len=1, class 0 (none) and role 0 (opcode).
- R3: The unprefixed 8-bit immediate forms are 00rrr110, 11xxx110, D3 and DB. Each is 2 bytes, and byte 2 has role 2 (immediate). The 16-bit forms are 00xx0001, 22, 2A, 32, 3A, C3, CD, 11ccc010 and 11ccc100. Each is 3 bytes, with roles 0,2,2 and the low byte first.
- R4: Relative branches 10, 18, 20, 28, 30 and 38 are 2 bytes. The offset byte has role 1 (displacement).
- R5: CB followed by any byte is 2 bytes, with class 1 and both roles 0.
- R6: Within ED, an opcode of the form 01xxx011 carries a 16-bit address. It is 4 bytes with roles 0,0,2,2. Every other ED opcode is 2 bytes. The class is 2.
- R7: DD or FD followed by an opcode with no memory operand is 2 bytes plus the opcode's unprefixed immediate count, with class 3. Examples are DD 84 (2 bytes), FD 26 n (3 bytes) and DD 21 nn nn (4 bytes).
- R8: After DD or FD, an opcode that uses the HL memory operand gains one displacement byte (role 1), placed before any immediate byte. These opcodes are 34, 35, 36, the 01xxxyyy forms with x or y equal to 6 (except 76), and 10xxx110. So DD 7E o is 3 bytes, and DD 36 o n is 4 bytes with roles 0,0,1,2. DD 76 stays 2 bytes.
- R9: DD or FD followed by CB is always 4 bytes, class 4, with roles 0,0,1,0. The displacement comes before the final opcode.
- R10: With in_valid low, no byte is taken, out_valid is 0 on the next cycle, and decoding resumes where it stopped.
- R11: DD or FD followed by ED, DD or FD forms a 2-byte instruction of class 3. The next byte starts a new instruction.
- R12: Each accepted byte appears on the outputs exactly one cycle later with out_valid=1. The byte after an out_last byte has out_first=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | High when a byte can be taken (after reset release) |
| in_byte | input | 8 | Instruction stream byte |
| out_valid | output | 1 | Tag outputs carry a byte this cycle |
| out_byte | output | 8 | The tagged byte |
| out_role | output | 2 | 0 opcode, 1 displacement/offset, 2 immediate |
| out_first | output | 1 | First byte of an instruction |
| out_last | output | 1 | Last byte of an instruction |
| out_len | output | 3 | Instruction length, valid with out_last |
| out_class | output | 3 | 0 none, 1 CB, 2 ED, 3 DD/FD, 4 DD/FD+CB, valid with out_last |

## Verification
The assertions assume that in_byte is meaningful whenever in_valid is high. They also assume the stream begins on an instruction boundary after reset, so a length is only ever checked against a class the decoder has itself chosen. The directed stimulus always starts each instruction at its first byte. It drives valid and data between clock edges and holds valid low for idle cycles. Each scenario closes its instructions before the next one begins, except where back-to-back chaining is the point under test.

// File: rtl/ild_pkg.sv
package ild_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 3;

  localparam logic [BYTE_W-1:0] PFX_BITOP = 8'hCB;
  localparam logic [BYTE_W-1:0] PFX_EXT   = 8'hED;
  localparam logic [BYTE_W-1:0] PFX_IDX0  = 8'hDD;
  localparam logic [BYTE_W-1:0] PFX_IDX1  = 8'hFD;

  typedef enum logic [1:0] {
    ROLE_OP   = 2'd0,
    ROLE_DISP = 2'd1,
    ROLE_IMM  = 2'd2
  } ild_role_e;

  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_BIT   = 3'd1,
    CLS_EXT   = 3'd2,
    CLS_IDX   = 3'd3,
    CLS_IDXBT = 3'd4
  } ild_cls_e;

  typedef enum logic [1:0] {
    MODE_BASE = 2'd0,
    MODE_IDX  = 2'd1,
    MODE_EXT  = 2'd2
  } ild_mode_e;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_BIT   = 3'd1,
    ST_EXT   = 3'd2,
    ST_IDX   = 3'd3,
    ST_XDISP = 3'd4,
    ST_XOP   = 3'd5,
    ST_OPND  = 3'd6
  } ild_state_e;
endpackage

// File: rtl/ild_operand_lut.sv
module ild_operand_lut
  import ild_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  input  ild_mode_e         mode,
  output logic              disp,
  output logic [1:0]        imm
);
  logic rel_br, imm8, imm16, mem_hl, ext_addr;

  always_comb begin
    rel_br = (opc[7:6] == 2'b00) && (opc[2:0] == 3'd0) && (opc[5] | opc[4]);
    imm8   = ((opc[7:6] == 2'b00) && (opc[2:0] == 3'd6)) ||
             ((opc[7:6] == 2'b11) && (opc[2:0] == 3'd6)) ||
             (opc == 8'hD3) || (opc == 8'hDB);
    imm16  = ((opc[7:6] == 2'b00) && (opc[3:0] == 4'h1)) ||
             (opc == 8'h22) || (opc == 8'h2A) || (opc == 8'h32) || (opc == 8'h3A) ||
             ((opc[7:6] == 2'b11) && (opc[2:0] == 3'd2)) ||
             ((opc[7:6] == 2'b11) && (opc[2:0] == 3'd4)) ||
             (opc == 8'hC3) || (opc == 8'hCD);
    mem_hl = (opc == 8'h34) || (opc == 8'h35) || (opc == 8'h36) ||
             ((opc[7:6] == 2'b01) && ((opc[2:0] == 3'd6) || (opc[5:3] == 3'd6)) &&
              (opc != 8'h76)) ||
             ((opc[7:6] == 2'b10) && (opc[2:0] == 3'd6));
    ext_addr = (opc[7:6] == 2'b01) && (opc[2:0] == 3'd3);

    disp = 1'b0;
    imm  = 2'd0;
    unique case (mode)
      MODE_EXT: begin
        imm = ext_addr ? 2'd2 : 2'd0;
      end
      MODE_IDX: begin
        disp = rel_br | mem_hl;
        imm  = imm16 ? 2'd2 : (imm8 ? 2'd1 : 2'd0);
      end
      default: begin
        disp = rel_br;
        imm  = imm16 ? 2'd2 : (imm8 ? 2'd1 : 2'd0);
      end
    endcase
  end
endmodule

// File: rtl/ild_sequencer.sv
module ild_sequencer
  import ild_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [BYTE_W-1:0] byte_i,
  output ild_role_e         role_o,
  output logic              first_o,
  output logic              last_o,
  output logic [LEN_W-1:0]  len_o,
  output ild_cls_e          cls_o
);
  ild_state_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             disp_q, disp_d;
  logic [1:0]       imm_q, imm_d;
  ild_cls_e         cls_q, cls_d;

  ild_mode_e  lut_mode;
  logic       lut_disp;
  logic [1:0] lut_imm;
  logic       is_pfx;

  always_comb begin
    unique case (state_q)
      ST_IDX:  lut_mode = MODE_IDX;
      ST_EXT:  lut_mode = MODE_EXT;
      default: lut_mode = MODE_BASE;
    endcase
  end

  ild_operand_lut u_lut (
    .opc  (byte_i),
    .mode (lut_mode),
    .disp (lut_disp),
    .imm  (lut_imm)
  );

  assign is_pfx = (byte_i == PFX_BITOP) || (byte_i == PFX_EXT) ||
                  (byte_i == PFX_IDX0) || (byte_i == PFX_IDX1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    disp_d  = disp_q;
    imm_d   = imm_q;
    cls_d   = cls_q;
    role_o  = ROLE_OP;
    last_o  = 1'b0;
    first_o = (state_q == ST_START);
    len_o   = cnt_q + 1'b1;

    unique case (state_q)
      ST_START: begin
        if (byte_i == PFX_BITOP) begin
          cls_d = CLS_BIT; state_d = ST_BIT;
        end else if (byte_i == PFX_EXT) begin
          cls_d = CLS_EXT; state_d = ST_EXT;
        end else if ((byte_i == PFX_IDX0) || (byte_i == PFX_IDX1)) begin
          cls_d = CLS_IDX; state_d = ST_IDX;
        end else begin
          cls_d = CLS_NONE;
          if (!lut_disp && (lut_imm == 2'd0)) last_o = 1'b1;
          else begin
            state_d = ST_OPND; disp_d = lut_disp; imm_d = lut_imm;
          end
        end
      end
      ST_BIT: last_o = 1'b1;
      ST_EXT: begin
        if (lut_imm == 2'd0) last_o = 1'b1;
        else begin
          state_d = ST_OPND; disp_d = 1'b0; imm_d = lut_imm;
        end
      end
      ST_IDX: begin
        if (byte_i == PFX_BITOP) begin
          cls_d = CLS_IDXBT; state_d = ST_XDISP;
        end else if (is_pfx) begin
          last_o = 1'b1;
        end else if (!lut_disp && (lut_imm == 2'd0)) begin
          last_o = 1'b1;
        end else begin
          state_d = ST_OPND; disp_d = lut_disp; imm_d = lut_imm;
        end
      end
      ST_XDISP: begin
        role_o = ROLE_DISP; state_d = ST_XOP;
      end
      ST_XOP: last_o = 1'b1;
      ST_OPND: begin
        if (disp_q) begin
          role_o = ROLE_DISP;
          disp_d = 1'b0;
          last_o = (imm_q == 2'd0);
        end else begin
          role_o = ROLE_IMM;
          imm_d  = imm_q - 1'b1;
          last_o = (imm_q == 2'd1);
        end
      end
      default: last_o = 1'b1;
    endcase

    if (last_o) begin
      state_d = ST_START;
      cnt_d   = '0;
    end
    cls_o = cls_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_START;
      cnt_q   <= '0;
      disp_q  <= 1'b0;
      imm_q   <= 2'd0;
      cls_q   <= CLS_NONE;
    end else if (acc) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      disp_q  <= disp_d;
      imm_q   <= imm_d;
      cls_q   <= cls_d;
    end
  end

  assert_hold_on_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(state_q) && $stable(cnt_q) && $stable(imm_q)));

  assert_restart_after_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last_o) |=> (state_q == ST_START));

  assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last_o) |-> ((len_o >= 1) && (len_o <= 4)));
endmodule

// File: rtl/opcode_len_decoder.sv
module opcode_len_decoder
  import ild_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [1:0]        out_role,
  output logic              out_first,
  output logic              out_last,
  output logic [LEN_W-1:0]  out_len,
  output logic [2:0]        out_class
);
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_int_n;
  logic                   acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rs_q[SYNC_STAGES-1];
  assign in_ready  = rst_int_n;
  assign acc       = in_valid && in_ready;

  ild_role_e        s_role;
  logic             s_first, s_last;
  logic [LEN_W-1:0] s_len;
  ild_cls_e         s_cls;

  ild_sequencer u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .acc     (acc),
    .byte_i  (in_byte),
    .role_o  (s_role),
    .first_o (s_first),
    .last_o  (s_last),
    .len_o   (s_len),
    .cls_o   (s_cls)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_valid <= 1'b0;
    else            out_valid <= acc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_byte  <= '0;
      out_role  <= ROLE_OP;
      out_first <= 1'b0;
      out_last  <= 1'b0;
      out_len   <= '0;
      out_class <= CLS_NONE;
    end else if (acc) begin
      out_byte  <= in_byte;
      out_role  <= s_role;
      out_first <= s_first;
      out_last  <= s_last;
      out_len   <= s_len;
      out_class <= s_cls;
    end
  end

  assert_out_follows_accept_R12: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc |=> out_valid);

  assert_no_spurious_out_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !acc |=> !out_valid);

  assert_double_prefix_len_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_last && (out_class == CLS_IDXBT)) |-> (out_len == 3'd4));

  assert_bitop_len_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && out_last && (out_class == CLS_BIT)) |-> (out_len == 3'd2));

  assert_ready_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> !in_ready);
endmodule

// File: tb/opcode_len_decoder_test.sv
module opcode_len_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_byte;
  logic       out_valid;
  logic [7:0] out_byte;
  logic [1:0] out_role;
  logic       out_first;
  logic       out_last;
  logic [2:0] out_len;
  logic [2:0] out_class;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam int OP = 0, DS = 1, IM = 2;
  localparam int C_NONE = 0, C_BIT = 1, C_EXT = 2, C_IDX = 3, C_IDXBT = 4;

  always #5 clk = ~clk;

  opcode_len_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_byte(out_byte),
    .out_role(out_role), .out_first(out_first), .out_last(out_last),
    .out_len(out_len), .out_class(out_class)
  );

  task automatic chk(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] b, input int role, input int first,
                      input int last, input int len, input int cls, input string rq);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(posedge clk);
    #2;
    chk(out_valid, 1, {rq, " out_valid"});
    chk(out_byte, b, {rq, " out_byte"});
    chk(out_role, role, {rq, " out_role"});
    chk(out_first, first, {rq, " out_first"});
    chk(out_last, last, {rq, " out_last"});
    if (last != 0) begin
      chk(out_len, len, {rq, " out_len"});
      chk(out_class, cls, {rq, " out_class"});
    end
  endtask

  task automatic idle(input int cycles, input string rq);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_byte  = 8'hA5;
      @(posedge clk);
      #2;
      chk(out_valid, 0, {rq, " idle out_valid"});
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(posedge clk);
    #2;
    chk(out_valid, 0, "R1 out_valid in reset");
    chk(in_ready, 0, "R1 in_ready in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready, 1, "R1 in_ready after release");
    chk(out_valid, 0, "R1 out_valid after release");
    step(8'h00, OP, 1, 1, 1, C_NONE, "R1 first byte after reset");
  endtask

  task automatic t_plain();
    step(8'hAF, OP, 1, 1, 1, C_NONE, "R2 xor");
    step(8'h76, OP, 1, 1, 1, C_NONE, "R2 halt");
    step(8'h80, OP, 1, 1, 1, C_NONE, "R12 back-to-back");
    idle(1, "R2");
  endtask

  task automatic t_imm();
    step(8'h06, OP, 1, 0, 0, 0, "R3 ld b,n");
    step(8'h55, IM, 0, 1, 2, C_NONE, "R3 ld b,n data");
    step(8'hFE, OP, 1, 0, 0, 0, "R3 cp n");
    step(8'h01, IM, 0, 1, 2, C_NONE, "R3 cp n data");
    step(8'hC3, OP, 1, 0, 0, 0, "R3 jp nn");
    step(8'h34, IM, 0, 0, 0, 0, "R3 jp low");
    step(8'h12, IM, 0, 1, 3, C_NONE, "R3 jp high");
    step(8'hCC, OP, 1, 0, 0, 0, "R3 call cc");
    step(8'h00, IM, 0, 0, 0, 0, "R3 call low");
    step(8'h40, IM, 0, 1, 3, C_NONE, "R3 call high");
    idle(1, "R3");
  endtask

  task automatic t_rel();
    step(8'h18, OP, 1, 0, 0, 0, "R4 jr");
    step(8'hFE, DS, 0, 1, 2, C_NONE, "R4 jr offset");
    step(8'h10, OP, 1, 0, 0, 0, "R4 djnz");
    step(8'h05, DS, 0, 1, 2, C_NONE, "R4 djnz offset");
    step(8'h08, OP, 1, 1, 1, C_NONE, "R4 08 not a branch");
    idle(1, "R4");
  endtask

  task automatic t_bit();
    step(8'hCB, OP, 1, 0, 0, 0, "R5 prefix");
    step(8'h47, OP, 0, 1, 2, C_BIT, "R5 bit op");
    step(8'hCB, OP, 1, 0, 0, 0, "R5 prefix 2");
    step(8'hDD, OP, 0, 1, 2, C_BIT, "R5 cb then dd byte");
    idle(1, "R5");
  endtask

  task automatic t_ext();
    step(8'hED, OP, 1, 0, 0, 0, "R6 prefix");
    step(8'h43, OP, 0, 0, 0, 0, "R6 addr form");
    step(8'h00, IM, 0, 0, 0, 0, "R6 addr low");
    step(8'hC0, IM, 0, 1, 4, C_EXT, "R6 addr high");
    step(8'hED, OP, 1, 0, 0, 0, "R6 prefix neg");
    step(8'h44, OP, 0, 1, 2, C_EXT, "R6 neg");
    step(8'hED, OP, 1, 0, 0, 0, "R6 prefix blk");
    step(8'hB0, OP, 0, 1, 2, C_EXT, "R6 block move");
    idle(1, "R6");
  endtask

  task automatic t_idx();
    step(8'hDD, OP, 1, 0, 0, 0, "R7 prefix");
    step(8'h84, OP, 0, 1, 2, C_IDX, "R7 add half");
    step(8'hFD, OP, 1, 0, 0, 0, "R7 prefix fd");
    step(8'h26, OP, 0, 0, 0, 0, "R7 ld half,n");
    step(8'h9C, IM, 0, 1, 3, C_IDX, "R7 ld half,n data");
    step(8'hDD, OP, 1, 0, 0, 0, "R7 prefix ld nn");
    step(8'h21, OP, 0, 0, 0, 0, "R7 ld ix,nn");
    step(8'h78, IM, 0, 0, 0, 0, "R7 low");
    step(8'h56, IM, 0, 1, 4, C_IDX, "R7 high");
    idle(1, "R7");
  endtask

  task automatic t_idxmem();
    step(8'hDD, OP, 1, 0, 0, 0, "R8 prefix");
    step(8'h7E, OP, 0, 0, 0, 0, "R8 ld a,(ix+o)");
    step(8'h80, DS, 0, 1, 3, C_IDX, "R8 disp");
    step(8'hFD, OP, 1, 0, 0, 0, "R8 prefix st");
    step(8'h36, OP, 0, 0, 0, 0, "R8 store imm");
    step(8'h02, DS, 0, 0, 0, 0, "R8 store disp");
    step(8'h99, IM, 0, 1, 4, C_IDX, "R8 store data");
    step(8'hDD, OP, 1, 0, 0, 0, "R8 prefix halt");
    step(8'h76, OP, 0, 1, 2, C_IDX, "R8 halt no disp");
    step(8'hDD, OP, 1, 0, 0, 0, "R8 prefix alu");
    step(8'h86, OP, 0, 0, 0, 0, "R8 add (ix+o)");
    step(8'h7F, DS, 0, 1, 3, C_IDX, "R8 alu disp");
    idle(1, "R8");
  endtask

  task automatic t_dbl();
    step(8'hDD, OP, 1, 0, 0, 0, "R9 prefix");
    step(8'hCB, OP, 0, 0, 0, 0, "R9 cb");
    step(8'h05, DS, 0, 0, 0, 0, "R9 disp");
    step(8'h46, OP, 0, 1, 4, C_IDXBT, "R9 final op");
    step(8'hFD, OP, 1, 0, 0, 0, "R9 prefix fd");
    step(8'hCB, OP, 0, 0, 0, 0, "R9 cb fd");
    step(8'hFF, DS, 0, 0, 0, 0, "R9 disp fd");
    step(8'h3E, OP, 0, 1, 4, C_IDXBT, "R9 final fd");
    idle(1, "R9");
  endtask

  task automatic t_stall();
    step(8'hDD, OP, 1, 0, 0, 0, "R10 prefix");
    idle(3, "R10");
    step(8'h36, OP, 0, 0, 0, 0, "R10 op after stall");
    idle(2, "R10");
    step(8'h10, DS, 0, 0, 0, 0, "R10 disp after stall");
    step(8'h20, IM, 0, 1, 4, C_IDX, "R10 data after stall");
    idle(1, "R10");
  endtask

  task automatic t_chain();
    step(8'hDD, OP, 1, 0, 0, 0, "R11 prefix");
    step(8'hFD, OP, 0, 1, 2, C_IDX, "R11 second prefix ends");
    step(8'h3C, OP, 1, 1, 1, C_NONE, "R11 next starts fresh");
    step(8'hFD, OP, 1, 0, 0, 0, "R11 prefix ed");
    step(8'hED, OP, 0, 1, 2, C_IDX, "R11 ed after fd");
    step(8'h44, OP, 1, 1, 1, C_NONE, "R11 44 plain");
    idle(1, "R11");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_plain();
    t_imm();
    t_rel();
    t_bit();
    t_ext();
    t_idx();
    t_idxmem();
    t_dbl();
    t_stall();
    t_chain();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule